// File: doc/BRIEF.md
# Acquisition Run Stream Gate

This block sits on a packet stream between a frontend data queue and a packet transmitter and decides whether frontend data may flow. A register write strobe carries two commands, distinguished only by address: a write to the start address opens the gate, and a write to the stop address closes it. The written data value plays no part in either command.

Each acquisition run is bracketed by two single-beat system messages that the block puts into the stream itself. One marks the beginning of the run and goes out ahead of any data packet. The other marks the end of the run and is the final packet of that run. The gate changes state only on packet boundaries. A stop that arrives while a packet is passing lets that packet finish in full. After the stop message, no more words are taken from the frontend. Words already handed downstream are left where they are.

The controller has five named states. STOPPED is the reset state. START_MSG presents the start message. GAP is a running state between packets. IN_PKT is a running state inside a packet. STOP_MSG presents the stop message. The transitions are:
- STOPPED→START_MSG on a start command.
- START_MSG→GAP when the message is accepted.
- START_MSG→STOP_MSG when the message is accepted and a stop is pending or arriving.
- GAP→IN_PKT when the first beat of a multi-beat packet is accepted.
- GAP→STOP_MSG on a stop command.
- IN_PKT→GAP when the last beat is accepted.
- IN_PKT→STOP_MSG when the last beat is accepted and a stop is pending or arriving.
- STOP_MSG→STOPPED when the message is accepted.

Top module: `daq_stream_gate`

## Requirements
- R1: After reset the gate is in STOPPED. In that state in_ready and out_valid are both 0.
- R2: A start command (cmd_wr_en=1 with cmd_addr=START_ADDR, any cmd_wdata) while STOPPED causes a start message on the next cycle, ahead of any data. The start message is a single beat with out_sys=1, out_first=1 and out_last=1. Its data is MSG_TYPE in the top 8 bits, zeros below that, and subtype 1 in the low 4 bits.
- R3: While running, each data beat passes unchanged with its first/last flags, out_sys=0 and in_ready equal to out_ready. Beats keep their order.
- R4: In STOPPED no frontend beat is accepted (in_ready=0) and nothing is presented on the output. This holds after a run has ended, even while the frontend keeps offering data.
- R5: A stop command (cmd_addr=STOP_ADDR) between packets accepts no further data beat. The next beat out is the stop message, which has subtype 2 in the low 4 bits and is otherwise framed like the start message. The gate then returns to STOPPED.
- R6: A stop command during a packet does not truncate it. Every remaining beat of that packet is passed, and the stop message follows its last beat.
- R7: A start command while running is ignored and adds no message. A stop command while STOPPED is ignored and produces no output.
- R8: A write to any address other than START_ADDR or STOP_ADDR has no effect.
- R9: A system message held back by out_ready=0 stays valid with unchanged data until it is accepted.
- R10: A stop command while the start message is still pending gives a run with no data: the start message, then the stop message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Register write strobe |
| cmd_addr | input | ADDR_W | Register write address |
| cmd_wdata | input | DATA_W | Register write data (ignored) |
| in_valid | input | 1 | Frontend beat valid |
| in_ready | output | 1 | Frontend beat taken |
| in_data | input | DATA_W | Frontend beat data |
| in_first | input | 1 | Frontend beat opens a packet |
| in_last | input | 1 | Frontend beat closes a packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Transmitter accepts beat |
| out_data | output | DATA_W | Output beat data |
| out_first | output | 1 | Output beat opens a packet |
| out_last | output | 1 | Output beat closes a packet |
| out_sys | output | 1 | Output beat is a system message |

## Verification
Two faults show up at the ports within one or two cycles of the command. A controller stuck in or returning wrongly to STOPPED leaves in_ready low while data is offered. A lost pending-stop flag lets a second packet through where the stop message belonged. A wrong choice of state at the packet boundary shows up as a stop message mid-packet, with a data beat following the out_sys beat, or as a missing bracket message in the output log. The sweep moves the stop command across every beat position of packets of one to three beats, under three back-pressure and gap patterns, so each boundary transition is exercised at each position.

// File: rtl/daq_gate_pkg.sv
package daq_gate_pkg;

    typedef enum logic [2:0] {
        ST_STOPPED   = 3'd0,
        ST_START_MSG = 3'd1,
        ST_GAP       = 3'd2,
        ST_IN_PKT    = 3'd3,
        ST_STOP_MSG  = 3'd4
    } gate_state_t;

    localparam int SUBTYPE_W = 4;
    localparam logic [SUBTYPE_W-1:0] SUB_START = 4'd1;
    localparam logic [SUBTYPE_W-1:0] SUB_STOP  = 4'd2;

endpackage

// File: rtl/daq_cmd_decode.sv
module daq_cmd_decode #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] START_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] STOP_ADDR  = 4'h1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              start_hit,
    output logic              stop_hit
);
    // The data value of a command write is deliberately discarded.
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        start_hit = wr_en && (addr == START_ADDR);
        stop_hit  = wr_en && (addr == STOP_ADDR);
    end
endmodule

// File: rtl/daq_gate_fsm.sv
module daq_gate_fsm
    import daq_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_hit,
    input  logic        stop_hit,
    input  logic        in_fire,
    input  logic        in_first,
    input  logic        in_last,
    input  logic        out_fire,
    output gate_state_t state
);
    gate_state_t state_d;
    logic        stop_pend_q;
    logic        stop_pend_d;

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_STOPPED;
            stop_pend_q <= 1'b0;
        end else begin
            state       <= state_d;
            stop_pend_q <= stop_pend_d;
        end
    end

    // Next-state process.
    always_comb begin
        state_d     = state;
        stop_pend_d = stop_pend_q;
        unique case (state)
            ST_STOPPED: begin
                stop_pend_d = 1'b0;
                if (start_hit) state_d = ST_START_MSG;
            end
            ST_START_MSG: begin
                if (stop_hit) stop_pend_d = 1'b1;
                if (out_fire) begin
                    if (stop_pend_q || stop_hit) begin
                        state_d     = ST_STOP_MSG;
                        stop_pend_d = 1'b0;
                    end else begin
                        state_d = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (stop_hit) begin
                    state_d = ST_STOP_MSG;
                end else if (in_fire && in_first && !in_last) begin
                    state_d = ST_IN_PKT;
                end
            end
            ST_IN_PKT: begin
                if (stop_hit) stop_pend_d = 1'b1;
                if (in_fire && in_last) begin
                    if (stop_pend_q || stop_hit) begin
                        state_d     = ST_STOP_MSG;
                        stop_pend_d = 1'b0;
                    end else begin
                        state_d = ST_GAP;
                    end
                end
            end
            ST_STOP_MSG: begin
                stop_pend_d = 1'b0;
                if (out_fire) state_d = ST_STOPPED;
            end
            default: begin
                state_d     = ST_STOPPED;
                stop_pend_d = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/daq_stream_mux.sv
module daq_stream_mux
    import daq_gate_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TYPE_W = 8,
    parameter logic [TYPE_W-1:0] MSG_TYPE = 8'hE5
) (
    input  gate_state_t       state,
    input  logic              stop_hit,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              out_sys
);
    localparam int PAD_W = DATA_W - TYPE_W - SUBTYPE_W;

    logic [DATA_W-1:0] start_word;
    logic [DATA_W-1:0] stop_word;

    assign start_word = {MSG_TYPE, {PAD_W{1'b0}}, SUB_START};
    assign stop_word  = {MSG_TYPE, {PAD_W{1'b0}}, SUB_STOP};

    // Output process: drives the stream from the current state.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_first = 1'b0;
        out_last  = 1'b0;
        out_sys   = 1'b0;
        unique case (state)
            ST_START_MSG, ST_STOP_MSG: begin
                out_valid = 1'b1;
                out_data  = (state == ST_START_MSG) ? start_word : stop_word;
                out_first = 1'b1;
                out_last  = 1'b1;
                out_sys   = 1'b1;
            end
            ST_GAP: begin
                if (!stop_hit) begin
                    in_ready  = out_ready;
                    out_valid = in_valid;
                    out_data  = in_data;
                    out_first = in_first;
                    out_last  = in_last;
                end
            end
            ST_IN_PKT: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_first = in_first;
                out_last  = in_last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/daq_stream_gate.sv
module daq_stream_gate
    import daq_gate_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int TYPE_W = 8,
    parameter logic [TYPE_W-1:0] MSG_TYPE   = 8'hE5,
    parameter logic [ADDR_W-1:0] START_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] STOP_ADDR  = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_en,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              out_sys
);
    gate_state_t gate_state;
    logic        start_hit;
    logic        stop_hit;
    logic        in_fire;
    logic        out_fire;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    daq_cmd_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .START_ADDR(START_ADDR), .STOP_ADDR(STOP_ADDR)
    ) u_dec (
        .wr_en(cmd_wr_en), .addr(cmd_addr), .wdata(cmd_wdata),
        .start_hit(start_hit), .stop_hit(stop_hit)
    );

    daq_gate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_hit(start_hit), .stop_hit(stop_hit),
        .in_fire(in_fire), .in_first(in_first), .in_last(in_last),
        .out_fire(out_fire), .state(gate_state)
    );

    daq_stream_mux #(
        .DATA_W(DATA_W), .TYPE_W(TYPE_W), .MSG_TYPE(MSG_TYPE)
    ) u_mux (
        .state(gate_state), .stop_hit(stop_hit),
        .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_last(in_last),
        .out_ready(out_ready), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data),
        .out_first(out_first), .out_last(out_last), .out_sys(out_sys)
    );
endmodule

// File: rtl/daq_stream_gate_chk.sv
module daq_stream_gate_chk
    import daq_gate_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int TYPE_W = 8,
    parameter logic [TYPE_W-1:0] MSG_TYPE   = 8'hE5,
    parameter logic [ADDR_W-1:0] START_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] STOP_ADDR  = 4'h1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr_en,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_first,
    input logic              out_last,
    input logic              out_sys,
    input gate_state_t       gate_state
);
    localparam int PAD_W = DATA_W - TYPE_W - SUBTYPE_W;
    localparam logic [DATA_W-1:0] W_START = {MSG_TYPE, {PAD_W{1'b0}}, SUB_START};
    localparam logic [DATA_W-1:0] W_STOP  = {MSG_TYPE, {PAD_W{1'b0}}, SUB_STOP};

    logic cmd_start;
    logic cmd_stop;
    assign cmd_start = cmd_wr_en && (cmd_addr == START_ADDR);
    assign cmd_stop  = cmd_wr_en && (cmd_addr == STOP_ADDR);

    p_stopped_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == ST_STOPPED) |-> (!in_ready && !out_valid));

    p_start_msg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == ST_STOPPED && cmd_start) |=>
            (out_valid && out_sys && out_first && out_last && out_data == W_START));

    p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (out_ready && !out_sys && out_valid == in_valid && out_data == in_data));

    p_stop_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == ST_GAP && cmd_stop) |=>
            (out_valid && out_sys && out_data == W_STOP));

    p_no_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == ST_IN_PKT && !(in_valid && in_ready && in_last)) |=>
            !out_sys);

    p_restart_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_state == ST_GAP && cmd_start) |=> !out_sys);

    p_msg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sys && !out_ready) |=>
            (out_valid && out_sys && $stable(out_data)));

    p_msg_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sys |-> (out_first && out_last));
endmodule

bind daq_stream_gate daq_stream_gate_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .MSG_TYPE(MSG_TYPE),
    .START_ADDR(START_ADDR), .STOP_ADDR(STOP_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_addr(cmd_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last), .out_sys(out_sys),
    .gate_state(gate_state)
);

// File: tb/daq_stream_gate_bench.sv
`timescale 1ns/100ps
module daq_stream_gate_bench;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam logic [AW-1:0] A_START = 4'h0;
    localparam logic [AW-1:0] A_STOP  = 4'h1;
    localparam logic [DW-1:0] W_START = {8'hE5, 20'h0, 4'd1};
    localparam logic [DW-1:0] W_STOP  = {8'hE5, 20'h0, 4'd2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr_en = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DW-1:0] in_data = '0;
    logic in_first = 1'b0;
    logic in_last = 1'b0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic out_first;
    logic out_last;
    logic out_sys;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0] log_data [0:63];
    logic          log_sys  [0:63];
    logic          log_fl   [0:63];
    int            log_n;

    always #2.5 clk = ~clk;

    daq_stream_gate u_daq_stream_gate (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_first(in_first), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last), .out_sys(out_sys)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] beat_word(input int p, input int b);
        return 32'hA000_0000 + 32'h100 * p + b;
    endfunction

    // One run: start at cycle 0, stop after n accepted beats (n=0: one cycle
    // after start), source offers two packets of L beats.
    task automatic run_case(input int L, input int n, input int mode,
                            input int restart_cyc, input string req);
        int src = 0;
        int acc = 0;
        int stop_cyc = (n == 0) ? 1 : -1;
        int c = 0;
        bit seen_stop = 1'b0;
        int exp_beats;
        int bad = 0;
        log_n = 0;
        while (!seen_stop && c < 300) begin
            @(negedge clk);
            cmd_wr_en = 1'b0;
            cmd_wdata = $urandom;
            if (c == 0) begin cmd_wr_en = 1'b1; cmd_addr = A_START; end
            if (c == restart_cyc) begin cmd_wr_en = 1'b1; cmd_addr = A_START; end
            if (c == stop_cyc) begin cmd_wr_en = 1'b1; cmd_addr = A_STOP; end
            case (mode)
                1: out_ready = c[0];
                2: out_ready = (c % 3) != 2;
                default: out_ready = 1'b1;
            endcase
            in_valid = (src < 2 * L) && !(mode == 2 && (c % 3) == 1);
            in_data  = beat_word(src / L, src % L);
            in_first = (src % L) == 0;
            in_last  = (src % L) == L - 1;
            #2;
            if (in_valid && in_ready) begin
                src++;
                acc++;
                if (n > 0 && acc == n) stop_cyc = c + 1;
            end
            if (out_valid && out_ready) begin
                log_data[log_n] = out_data;
                log_sys[log_n]  = out_sys;
                log_fl[log_n]   = out_first && out_last;
                if (out_sys && out_data == W_STOP) seen_stop = 1'b1;
                log_n++;
            end
            c++;
        end
        cmd_wr_en = 1'b0;
        exp_beats = ((n + L - 1) / L) * L;
        check(log_n == exp_beats + 2, req, log_n, exp_beats + 2);
        if (log_n == exp_beats + 2) begin
            if (!(log_sys[0] && log_fl[0] && log_data[0] == W_START)) bad++;
            for (int i = 0; i < exp_beats; i++)
                if (log_sys[i+1] || log_data[i+1] != beat_word(i / L, i % L)) bad++;
            if (!(log_sys[exp_beats+1] && log_fl[exp_beats+1])) bad++;
        end
        check(bad == 0, req, bad, 0);
        // After the run the frontend keeps offering; nothing may be taken.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            out_ready = 1'b1;
            #2;
            if (in_ready || out_valid) bad++;
        end
        check(bad == 0, "R4", bad, 0);
        in_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(!in_ready && !out_valid, "R1", {in_ready, out_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b1;
        out_ready = 1'b1;
        #2;
        check(!in_ready && !out_valid, "R1", {in_ready, out_valid}, 0);

        // R8: writes elsewhere do nothing.
        for (int a = 2; a < 16; a++) begin
            @(negedge clk);
            cmd_wr_en = 1'b1; cmd_addr = a[AW-1:0]; cmd_wdata = $urandom;
            @(negedge clk);
            cmd_wr_en = 1'b0;
            #2;
            check(!in_ready && !out_valid, "R8", {in_ready, out_valid}, 0);
        end

        // R7: stop while stopped gives no output.
        @(negedge clk);
        cmd_wr_en = 1'b1; cmd_addr = A_STOP;
        @(negedge clk);
        cmd_wr_en = 1'b0;
        #2;
        check(!out_valid && !in_ready, "R7", {in_ready, out_valid}, 0);
        in_valid = 1'b0;

        // R9: start message held while out_ready is low.
        @(negedge clk);
        out_ready = 1'b0;
        cmd_wr_en = 1'b1; cmd_addr = A_START;
        @(negedge clk);
        cmd_wr_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #2;
            check(out_valid && out_sys && out_data == W_START, "R9", out_data, W_START);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        cmd_wr_en = 1'b1; cmd_addr = A_STOP;
        @(negedge clk);
        cmd_wr_en = 1'b0;
        #2;
        check(out_valid && out_sys && out_data == W_STOP, "R5", out_data, W_STOP);
        @(negedge clk);
        #2;
        check(!out_valid, "R4", out_valid, 0);

        // Sweep stop position across packet lengths and flow patterns.
        for (int L = 1; L <= 3; L++)
            for (int n = 0; n < 2 * L; n++)
                for (int m = 0; m < 3; m++)
                    run_case(L, n, m, -1,
                             (n == 0) ? "R10" : ((n % L) == 0 ? "R5 R3 R2" : "R6 R3 R2"));

        // R7: second start mid-run adds nothing.
        run_case(2, 3, 0, 3, "R7");
        run_case(1, 2, 1, 2, "R7");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule